// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This block executes the single-register class of byte operations that sit behind an opcode prefix in a small 8-bit processor. It covers circular rotates, rotates through carry, three kinds of shift, a nibble swap, and test, clear and set of one indexed bit. Each operation returns a result byte and an updated Z, N, H, C flag set, with its own rule for every flag.

The surrounding datapath supplies the operand byte read from the selected register, the current flags, an operation code and a 3-bit bit index, and pulses `in_valid`. One clock later the unit presents the result, a write-enable for the operand's own register, the new flags and `out_valid`. The write always goes back to the register that supplied the operand and never to the accumulator. Register selection and memory operands are handled outside this block.

Top module: `sbr_unit`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` delayed by one clock. `result`, `wr_en` and `flags_out` update only on a clock where `in_valid` is high, and they hold their values on any clock where it is low.
- R2: While `rst_n` is low, `out_valid`, `result`, `wr_en` and `flags_out` are all zero.
- R3: Op code 0 (circular left) returns the operand rotated left by one, with old bit 7 in bit 0 and in C. Op code 1 (circular right) returns it rotated right by one, with old bit 0 in bit 7 and in C.
- R4: Op code 2 (left through carry) shifts left, puts the incoming C in bit 0 and loads old bit 7 into C. Op code 3 (right through carry) shifts right, puts the incoming C in bit 7 and loads old bit 0 into C.
- R5: Op code 4 (arithmetic left) shifts left with a 0 fill and old bit 7 to C. Op code 5 (arithmetic right) keeps bit 7 and copies it down one place. Op code 6 (logical right) fills bit 7 with 0. Both right shifts send old bit 0 to C.
- R6: Flags are packed as bit 3 Z, bit 2 N, bit 1 H, bit 0 C. For op codes 0 to 7, N and H are cleared and Z is 1 exactly when the result byte is zero.
- R7: Op code 7 (swap) exchanges the two nibbles of the operand and clears C.
- R8: Op code 8 (bit test) sets Z to the inverse of operand bit `bit_idx`, sets H, clears N, keeps the incoming C, returns the operand unchanged and deasserts `wr_en`.
- R9: Op code 9 clears operand bit `bit_idx` and op code 10 sets it. All other bits are left unchanged, and `flags_out` equals `flags_in`.
- R10: `wr_en` is 1 for op codes 0 to 7, 9 and 10. Op codes 11 to 15 return the operand unchanged, pass `flags_in` through and deassert `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request for this cycle |
| op_sel | input | 4 | Operation code |
| bit_idx | input | 3 | Bit index for test, clear and set |
| operand | input | 8 | Source register byte |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| result | output | 8 | Byte to write back to the source register |
| wr_en | output | 1 | Write the result back |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |

## Verification
The hardest cases to reach are those where the outcome depends on the incoming carry together with the operand edge bits. One example is a through-carry rotate that yields zero only when the incoming C is clear. Another is a bit test whose Z output depends on one of eight index positions. The stimulus sweeps all 256 operand values under two flag patterns that drive C both ways, and for the bit operations it also crosses every index. Directed vectors first pin the zero-result and all-ones edges. Further directed steps then hold `in_valid` low while the inputs change, to show that the outputs stay put.

// File: rtl/sbr_pkg.sv
// Shared operation codes and flag layout for the shift, rotate and bit unit.
// Assumes a 4-bit operation field; codes 11..15 are reserved.
package sbr_pkg;
    typedef enum logic [3:0] {
        OP_ROL_CIRC  = 4'd0,
        OP_ROR_CIRC  = 4'd1,
        OP_ROL_CARRY = 4'd2,
        OP_ROR_CARRY = 4'd3,
        OP_SHL_ARITH = 4'd4,
        OP_SHR_ARITH = 4'd5,
        OP_SHR_LOGIC = 4'd6,
        OP_NIB_SWAP  = 4'd7,
        OP_BIT_TEST  = 4'd8,
        OP_BIT_CLR   = 4'd9,
        OP_BIT_SET   = 4'd10
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;
endpackage

// File: rtl/sbr_shift_path.sv
// Combinational rotate / shift / swap datapath.
// Produces the shifted byte and the carry-out for op codes 0..7.
// Assumes DW is even so the swap splits the word into equal halves.
module sbr_shift_path #(
    parameter int DW = 8
) (
    input  sbr_pkg::op_e    op,
    input  logic [DW-1:0]   din,
    input  logic            cin,
    output logic [DW-1:0]   dout,
    output logic            cout
);
    import sbr_pkg::*;
    localparam int HW = DW / 2;

    // Select the shifted word and the bit that falls out into carry.
    always_comb begin
        dout = din;
        cout = 1'b0;
        case (op)
            OP_ROL_CIRC:  begin dout = {din[DW-2:0], din[DW-1]}; cout = din[DW-1]; end
            OP_ROR_CIRC:  begin dout = {din[0], din[DW-1:1]};    cout = din[0];    end
            OP_ROL_CARRY: begin dout = {din[DW-2:0], cin};       cout = din[DW-1]; end
            OP_ROR_CARRY: begin dout = {cin, din[DW-1:1]};       cout = din[0];    end
            OP_SHL_ARITH: begin dout = {din[DW-2:0], 1'b0};      cout = din[DW-1]; end
            OP_SHR_ARITH: begin dout = {din[DW-1], din[DW-1:1]}; cout = din[0];    end
            OP_SHR_LOGIC: begin dout = {1'b0, din[DW-1:1]};      cout = din[0];    end
            OP_NIB_SWAP:  begin dout = {din[HW-1:0], din[DW-1:HW]}; cout = 1'b0;   end
            default:      begin dout = din; cout = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sbr_bit_path.sv
// Combinational single-bit datapath: decodes the index into a one-hot mask,
// reports the addressed bit and forms the cleared or set word.
// Assumes idx < DW (IW = clog2(DW) with DW a power of two).
module sbr_bit_path #(
    parameter int DW = 8,
    parameter int IW = $clog2(DW)
) (
    input  logic [IW-1:0]   idx,
    input  logic [DW-1:0]   din,
    input  logic            set_not_clr,
    output logic [DW-1:0]   dout,
    output logic            bit_val
);
    logic [DW-1:0] mask;

    // One decoder slice per bit position.
    for (genvar i = 0; i < DW; i++) begin : g_dec
        assign mask[i] = (idx == IW'(i));
    end

    // Read the addressed bit and build the modified word.
    always_comb begin
        bit_val = |(din & mask);
        dout    = set_not_clr ? (din | mask) : (din & ~mask);
    end
endmodule

// File: rtl/sbr_out_reg.sv
// Output stage: a valid flop plus a load-enabled data register.
// Data loads only when 'load' is high, otherwise it holds; reset clears all.
module sbr_out_reg #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         vld,
    output logic [W-1:0] q
);
    // Track the valid strobe one cycle behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= load;
    end

    // Capture the payload on accepted cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/sbr_unit.sv
// Top of the prefixed shift / rotate / bit unit.
// Combines the shift and bit datapaths, applies the per-operation flag
// rules and registers result, write-enable and flags one clock after
// in_valid. Assumes the caller routes result back to the source register.
module sbr_unit #(
    parameter int DW = 8,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op_sel,
    input  logic [IW-1:0] bit_idx,
    input  logic [DW-1:0] operand,
    input  logic [3:0]    flags_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic [3:0]    flags_out
);
    import sbr_pkg::*;
    localparam int PW = DW + 1 + 4;

    op_e           op;
    flags_t        fin;
    flags_t        fnext;
    logic [DW-1:0] sh_res;
    logic          sh_c;
    logic [DW-1:0] bt_res;
    logic          bt_val;
    logic [DW-1:0] nxt_res;
    logic          nxt_we;
    logic [PW-1:0] pay_q;

    assign op  = op_e'(op_sel);
    assign fin = flags_t'(flags_in);

    sbr_shift_path #(.DW(DW)) u_shift (
        .op   (op),
        .din  (operand),
        .cin  (fin.c),
        .dout (sh_res),
        .cout (sh_c)
    );

    sbr_bit_path #(.DW(DW), .IW(IW)) u_bit (
        .idx         (bit_idx),
        .din         (operand),
        .set_not_clr (op == OP_BIT_SET),
        .dout        (bt_res),
        .bit_val     (bt_val)
    );

    // Pick the result, write-enable and flag rule for this operation.
    always_comb begin
        nxt_res = operand;
        nxt_we  = 1'b0;
        fnext   = fin;
        case (op)
            OP_ROL_CIRC, OP_ROR_CIRC, OP_ROL_CARRY, OP_ROR_CARRY,
            OP_SHL_ARITH, OP_SHR_ARITH, OP_SHR_LOGIC, OP_NIB_SWAP: begin
                nxt_res = sh_res;
                nxt_we  = 1'b1;
                fnext   = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_c};
            end
            OP_BIT_TEST: begin
                fnext = '{z: ~bt_val, n: 1'b0, h: 1'b1, c: fin.c};
            end
            OP_BIT_CLR, OP_BIT_SET: begin
                nxt_res = bt_res;
                nxt_we  = 1'b1;
            end
            default: ;
        endcase
    end

    sbr_out_reg #(.W(PW)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_valid),
        .d     ({nxt_res, nxt_we, fnext}),
        .vld   (out_valid),
        .q     (pay_q)
    );

    assign result    = pay_q[PW-1 -: DW];
    assign wr_en     = pay_q[4];
    assign flags_out = pay_q[3:0];
endmodule

// File: rtl/sbr_unit_chk.sv
// Property checker for sbr_unit, bound to every instance of it.
// Assumes the flag layout {Z,N,H,C} and op codes from sbr_pkg.
module sbr_unit_chk #(
    parameter int DW = 8,
    parameter int IW = $clog2(DW)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    op_sel,
    input logic [IW-1:0] bit_idx,
    input logic [DW-1:0] operand,
    input logic [3:0]    flags_in,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic          wr_en,
    input logic [3:0]    flags_out
);
    logic is_sh;
    logic is_bt;
    logic is_rs;
    assign is_sh = in_valid && (op_sel <= 4'd7);
    assign is_bt = in_valid && (op_sel == 4'd8);
    assign is_rs = in_valid && ((op_sel == 4'd9) || (op_sel == 4'd10));

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(wr_en) && $stable(flags_out))); // R1
    AST_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        is_sh |=> (!flags_out[2] && !flags_out[1] && (flags_out[3] == (result == '0)) && wr_en)); // R6
    AST_SWAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd7) |=> !flags_out[0]); // R7
    AST_TEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        is_bt |=> (!wr_en && flags_out[1] && !flags_out[2] && (flags_out[0] == $past(flags_in[0]))
                   && (flags_out[3] == !$past(operand[bit_idx])) && (result == $past(operand)))); // R8
    AST_RESSET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        is_rs |=> (wr_en && (flags_out == $past(flags_in)))); // R9
    AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 4'd11) |=> (!wr_en && (result == $past(operand)) && (flags_out == $past(flags_in)))); // R10
endmodule

bind sbr_unit sbr_unit_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .bit_idx   (bit_idx),
    .operand   (operand),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .flags_out (flags_out)
);

// File: tb/sbr_unit_tb.sv
`timescale 1ns/1ps
// Bench for sbr_unit: a directed vector table, an exhaustive sweep, then
// reset and idle-hold checks. Expected values come from a local model.
module sbr_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [2:0] bit_idx = '0;
    logic [7:0] operand = '0;
    logic [3:0] flags_in = '0;
    logic       out_valid;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sbr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .bit_idx(bit_idx), .operand(operand), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .flags_out(flags_out)
    );

    // {op, idx, operand, flags_in, exp result, exp wr_en, exp flags}
    localparam logic [31:0] VEC [14] = '{
        {4'd0,  3'd0, 8'h85, 4'b0000, 8'h0B, 1'b1, 4'b0001},
        {4'd1,  3'd0, 8'h01, 4'b0000, 8'h80, 1'b1, 4'b0001},
        {4'd2,  3'd0, 8'h80, 4'b0000, 8'h00, 1'b1, 4'b1001},
        {4'd3,  3'd0, 8'h01, 4'b0001, 8'h80, 1'b1, 4'b0001},
        {4'd4,  3'd0, 8'hFF, 4'b0000, 8'hFE, 1'b1, 4'b0001},
        {4'd5,  3'd0, 8'h81, 4'b0000, 8'hC0, 1'b1, 4'b0001},
        {4'd6,  3'd0, 8'h01, 4'b0000, 8'h00, 1'b1, 4'b1001},
        {4'd7,  3'd0, 8'hF0, 4'b1111, 8'h0F, 1'b1, 4'b0000},
        {4'd7,  3'd0, 8'h00, 4'b0001, 8'h00, 1'b1, 4'b1000},
        {4'd8,  3'd7, 8'h7F, 4'b0101, 8'h7F, 1'b0, 4'b1011},
        {4'd8,  3'd0, 8'h01, 4'b1100, 8'h01, 1'b0, 4'b0010},
        {4'd9,  3'd3, 8'hFF, 4'b1010, 8'hF7, 1'b1, 4'b1010},
        {4'd10, 3'd6, 8'h00, 4'b0101, 8'h40, 1'b1, 4'b0101},
        {4'd15, 3'd0, 8'h5A, 4'b0110, 8'h5A, 1'b0, 4'b0110}
    };

    // Requirement tag for an op code.
    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd1) return "R3";
        if (op <= 4'd3) return "R4";
        if (op <= 4'd6) return "R5";
        if (op == 4'd7) return "R7";
        if (op == 4'd8) return "R8";
        if (op <= 4'd10) return "R9";
        return "R10";
    endfunction

    // Reference model written from the requirements: {result, wr_en, flags}.
    function automatic logic [12:0] model(input logic [3:0] op, input logic [2:0] k,
                                          input logic [7:0] a, input logic [3:0] f);
        logic [7:0] r;
        logic c;
        logic [3:0] fo;
        logic we;
        r = a; c = 1'b0; we = 1'b1; fo = f;
        case (op)
            4'd0: begin r = (a << 1) | (a >> 7); c = a[7]; end
            4'd1: begin r = (a >> 1) | (a << 7); c = a[0]; end
            4'd2: begin r = (a << 1) | {7'd0, f[0]}; c = a[7]; end
            4'd3: begin r = (a >> 1) | {f[0], 7'd0}; c = a[0]; end
            4'd4: begin r = a << 1; c = a[7]; end
            4'd5: begin r = (a >> 1) | (a & 8'h80); c = a[0]; end
            4'd6: begin r = a >> 1; c = a[0]; end
            4'd7: begin r = (a << 4) | (a >> 4); c = 1'b0; end
            default: ;
        endcase
        if (op <= 4'd7) fo = {(r == 8'd0), 1'b0, 1'b0, c};
        else if (op == 4'd8) begin we = 1'b0; fo = {~((a >> k) & 8'd1) == 8'hFF, 1'b0, 1'b1, f[0]}; end
        else if (op == 4'd9) r = a & ~(8'd1 << k);
        else if (op == 4'd10) r = a | (8'd1 << k);
        else we = 1'b0;
        return {r, we, fo};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Issue one operation and compare outputs after the register stage.
    task automatic run_op(input logic [3:0] op, input logic [2:0] k,
                          input logic [7:0] a, input logic [3:0] f, input logic [12:0] expv);
        @(negedge clk);
        op_sel = op; bit_idx = k; operand = a; flags_in = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag_of(op), "outputs", {19'd0, out_valid, result, wr_en, flags_out}, {19'd1, expv});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2: reset clears all outputs
        repeat (3) @(negedge clk);
        check("R2", "reset", {27'd0, out_valid, result, wr_en, flags_out}, 32'd0);
        rst_n = 1'b1;

        // Directed table (R3..R10 edges, R6 zero results)
        for (int i = 0; i < 14; i++)
            run_op(VEC[i][31:28], VEC[i][27:25], VEC[i][24:17], VEC[i][16:13], VEC[i][12:0]);

        // Exhaustive sweep: every op, operand, index (bit ops) and two flag patterns
        for (int op = 0; op < 11; op++)
            for (int fp = 0; fp < 2; fp++)
                for (int a = 0; a < 256; a++)
                    for (int k = 0; k < ((op >= 8) ? 8 : 1); k++) begin
                        logic [3:0] f;
                        f = fp ? 4'b0101 : 4'b1010;
                        run_op(4'(op), 3'(k), 8'(a), f, model(4'(op), 3'(k), 8'(a), f));
                    end

        // R10: reserved codes 11..15
        for (int op = 11; op < 16; op++)
            run_op(4'(op), 3'd2, 8'hC3, 4'b1001, {8'hC3, 1'b0, 4'b1001});

        // R1: idle cycles hold outputs while inputs change
        run_op(4'd0, 3'd0, 8'h40, 4'b0000, {8'h80, 1'b1, 4'b0000});
        @(negedge clk);
        op_sel = 4'd9; operand = 8'hFF; flags_in = 4'hF;
        @(negedge clk);
        @(negedge clk);
        check("R1", "idle hold", {19'd0, out_valid, result, wr_en, flags_out}, {19'd0, 1'b0, 8'h80, 1'b1, 4'b0000});

        // R1: back-to-back requests each appear one clock later
        @(negedge clk);
        op_sel = 4'd7; operand = 8'h12; flags_in = 4'h0; in_valid = 1'b1;
        @(negedge clk);
        check("R1", "b2b first", {19'd0, out_valid, result, wr_en, flags_out}, {19'd1, 8'h21, 1'b1, 4'b0000});
        op_sel = 4'd8; bit_idx = 3'd4; operand = 8'h10; flags_in = 4'h1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "b2b second", {19'd0, out_valid, result, wr_en, flags_out}, {19'd1, 8'h10, 1'b0, 4'b0011});

        // R2: reset after activity clears outputs again
        rst_n = 1'b0;
        @(negedge clk);
        check("R2", "re-reset", {27'd0, out_valid, result, wr_en, flags_out}, 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule